// File: doc/BRIEF.md
# Multi-Cycle Instruction Fetch and Program Counter Sequencer

This block is the front end of a small CPU that retires one instruction every five cycles. A one-hot stage ring steps each instruction through fetch, decode, register read, execute and writeback. A program-counter unit sits beside the ring. It is driven by a 2-bit operation code: clear, step, load or keep. The counter drives the instruction memory address directly. Whatever the memory returns is captured as the current instruction when the fetch stage ends.

The counter moves only when writeback ends. It steps by one, or it takes the ALU result when the branch-taken flag is raised in that stage. Fetch is a full stage of its own, which gives the memory one cycle to answer. As a result, the fetch that follows a taken branch already sees the target word, and no delay slot is needed. The register file, ALU and data memory live elsewhere and reach this block only as the branch flag and the ALU result.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counter is cleared to 0, the stage ring is set to fetch (`stage_en` = 5'b00001) and the held instruction is cleared to 0.
- R2: `stage_en` is always one-hot with bit 0 fetch, bit 1 decode, bit 2 register read, bit 3 execute and bit 4 writeback. It advances one position per cycle and wraps from writeback to fetch.
- R3: `mem_addr` is unchanged across any edge at which the stage is not writeback.
- R4: At the edge that ends writeback with `branch_taken` low, the counter becomes its old value plus one.
- R5: At the edge that ends writeback with `branch_taken` high, the counter takes `alu_result`.
- R6: `branch_taken` and `alu_result` have no effect in any stage other than writeback.
- R7: `mem_addr` equals the counter at all times. At the edge that ends fetch, `instr` takes the `mem_rdata` word addressed by the counter.
- R8: `instr` holds its value at every edge other than the end of fetch, including the edge at which writeback changes the counter.
- R9: After a taken branch, the next fetch captures the word stored at the branch target.
- R10: Stepping the counter wraps modulo 2^ADDR_W, so stepping from the top address gives 0.
- R11: A reset asserted in the middle of an instruction takes priority over every stage and over `branch_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| branch_taken | input | 1 | ALU decision to branch; sampled only in writeback |
| alu_result | input | ADDR_W | Branch target offered by the ALU |
| mem_rdata | input | INSTR_W | Read data from the instruction memory |
| mem_addr | output | ADDR_W | Instruction memory address, equal to the counter |
| instr | output | INSTR_W | Instruction captured at the end of fetch |
| stage_en | output | 5 | One-hot stage enables, bit 0 fetch to bit 4 writeback |

## Verification
The bench builds the block with ADDR_W = 4 and INSTR_W = 16, so the memory has 16 words.

The 16-word space is small enough that a directed loop program is practical. That program branches backwards twice from address 5 to address 2 and stops once the counter reaches 8. The same small space makes address wrap-around from 15 to 0 reachable within a few instructions.

Each memory word is a distinct function of its address. Because of this, any stale or delay-slot fetch after a branch shows up as a mismatched instruction. A random phase raises the branch flag and the ALU value in every stage, so the bench can confirm that these inputs only matter in writeback.

// File: rtl/fetch_pc_pkg.sv
// Shared definitions for the fetch / program-counter sequencer.
// Assumes a five-stage, one-instruction-at-a-time sequence.
package fetch_pc_pkg;

    // Operation applied to the program counter at the next rising edge.
    typedef enum logic [1:0] {
        PCOP_CLEAR = 2'b00,
        PCOP_STEP  = 2'b01,
        PCOP_LOAD  = 2'b10,
        PCOP_KEEP  = 2'b11
    } pc_op_e;

    localparam int N_STAGES  = 5;
    localparam int ST_FETCH  = 0;
    localparam int ST_DECODE = 1;
    localparam int ST_RDREG  = 2;
    localparam int ST_EXEC   = 3;
    localparam int ST_WBACK  = 4;

endpackage

// File: rtl/fetch_stage_ring.sv
// One-hot stage ring. Reset places the token on fetch (bit 0).
// After that the token moves one position per cycle and wraps from the last stage back to fetch.
// Assumes N >= 2.
module fetch_stage_ring #(
    parameter int N = fetch_pc_pkg::N_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [N-1:0] stage
);

    localparam logic [N-1:0] FIRST = {{(N-1){1'b0}}, 1'b1};

    // Rotate the one-hot token, or reload it onto fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= FIRST;
        else        stage <= {stage[N-2:0], stage[N-1]};
    end

endmodule

// File: rtl/fetch_pc_ctrl.sv
// Chooses the program-counter operation for the next edge.
// Priority: reset first, then a branch in writeback, then a step in writeback; otherwise keep.
// Assumes the branch flag is only meaningful in writeback.
module fetch_pc_ctrl
    import fetch_pc_pkg::*;
(
    input  logic   rst_n,
    input  logic   in_wback,
    input  logic   branch_taken,
    output pc_op_e pc_op
);

    // Decode reset, stage and branch flag into one operation.
    always_comb begin
        if (!rst_n)            pc_op = PCOP_CLEAR;
        else if (!in_wback)    pc_op = PCOP_KEEP;
        else if (branch_taken) pc_op = PCOP_LOAD;
        else                   pc_op = PCOP_STEP;
    end

endmodule

// File: rtl/fetch_pc_reg.sv
// Program-counter register. Applies the operation code present at each rising edge.
// A step wraps modulo 2**W.
module fetch_pc_reg
    import fetch_pc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  pc_op_e       pc_op,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] pc
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Carry out the selected counter operation.
    always_ff @(posedge clk) begin
        case (pc_op)
            PCOP_CLEAR: pc <= '0;
            PCOP_STEP:  pc <= pc + ONE;
            PCOP_LOAD:  pc <= load_val;
            default:    pc <= pc;
        endcase
    end

endmodule

// File: rtl/fetch_ir_latch.sv
// Instruction holding register. Captures memory read data when capture is high.
// Holds otherwise, and clears on reset.
module fetch_ir_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Load on capture and hold the rest of the time.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (capture) q <= d;
    end

endmodule

// File: rtl/fetch_pc_sequencer.sv
// Top of the fetch front end: stage ring, counter control, counter register and instruction latch.
// The memory address is the counter itself. Read data must be valid by the end of the fetch cycle.
module fetch_pc_sequencer
    import fetch_pc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INSTR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                branch_taken,
    input  logic [ADDR_W-1:0]   alu_result,
    input  logic [INSTR_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [INSTR_W-1:0]  instr,
    output logic [N_STAGES-1:0] stage_en
);

    pc_op_e              pc_op;
    logic [ADDR_W-1:0]   pc;
    logic [N_STAGES-1:0] stage;

    fetch_stage_ring #(.N(N_STAGES)) ring_i (
        .clk   (clk),
        .rst_n (rst_n),
        .stage (stage)
    );

    fetch_pc_ctrl ctrl_i (
        .rst_n        (rst_n),
        .in_wback     (stage[ST_WBACK]),
        .branch_taken (branch_taken),
        .pc_op        (pc_op)
    );

    fetch_pc_reg #(.W(ADDR_W)) pc_i (
        .clk      (clk),
        .pc_op    (pc_op),
        .load_val (alu_result),
        .pc       (pc)
    );

    fetch_ir_latch #(.W(INSTR_W)) ir_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (stage[ST_FETCH]),
        .d       (mem_rdata),
        .q       (instr)
    );

    assign mem_addr = pc;
    assign stage_en = stage;

endmodule

// File: rtl/fetch_pc_sequencer_chk.sv
// Checker for fetch_pc_sequencer. It watches only the top-level ports and is attached with bind.
module fetch_pc_sequencer_chk #(
    parameter int ADDR_W  = 8,
    parameter int INSTR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               branch_taken,
    input logic [ADDR_W-1:0]  alu_result,
    input logic [INSTR_W-1:0] mem_rdata,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [INSTR_W-1:0] instr,
    input logic [4:0]         stage_en
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    assert_stage_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(stage_en) == 1);

    assert_wrap_to_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && stage_en[4]) |=> stage_en[0]);

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stage_en[4])) |-> $stable(mem_addr));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stage_en[4]) && !$past(branch_taken))
            |-> mem_addr == $past(mem_addr) + ONE);

    assert_pc_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stage_en[4]) && $past(branch_taken))
            |-> mem_addr == $past(alu_result));

    assert_instr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stage_en[0])) |-> $stable(instr));

    assert_instr_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stage_en[0])) |-> instr == $past(mem_rdata));

    assert_reset_state_R1: assert property (@(posedge clk)
        (rst_n && $past(rst_n) == 1'b0 && $past(stage_en) !== 5'bx)
            |-> (mem_addr == '0 && stage_en == 5'b00001));

endmodule

bind fetch_pc_sequencer fetch_pc_sequencer_chk #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .branch_taken (branch_taken),
    .alu_result   (alu_result),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .instr        (instr),
    .stage_en     (stage_en)
);

// File: tb/fetch_pc_sequencer_tb_top.sv
// Self-checking bench for fetch_pc_sequencer. It uses a behavioural memory and a reference model kept in bench variables.
module fetch_pc_sequencer_tb_top;

    localparam int AW = 4;
    localparam int IW = 16;
    localparam time PERIOD = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          branch_taken = 1'b0;
    logic [AW-1:0] alu_result = '0;
    logic [IW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [IW-1:0] instr;
    logic [4:0]    stage_en;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    logic [AW-1:0] m_pc    = '0;
    logic [4:0]    m_stage = 5'b00001;
    logic [IW-1:0] m_instr = '0;

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [IW-1:0] memf(input logic [AW-1:0] a);
        return 16'h3C00 + 16'({a, a} * 16'h0101) ^ 16'h0055;
    endfunction

    assign mem_rdata = memf(mem_addr);

    fetch_pc_sequencer #(.ADDR_W(AW), .INSTR_W(IW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .branch_taken (branch_taken),
        .alu_result   (alu_result),
        .mem_rdata    (mem_rdata),
        .mem_addr     (mem_addr),
        .instr        (instr),
        .stage_en     (stage_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock cycle: drive, clock, update the model, then compare at the falling edge.
    task automatic cyc(input logic bt, input logic [AW-1:0] tgt, input logic r);
        string pc_req;
        string ir_req;
        logic  was_wb;
        logic  was_f;
        rst_n = r; branch_taken = bt; alu_result = tgt;
        was_wb = m_stage[4];
        was_f  = m_stage[0];
        @(posedge clk);
        if (!r) begin
            m_pc = '0; m_stage = 5'b00001; m_instr = '0;
            pc_req = "R11"; ir_req = "R11";
        end else begin
            if (was_f) m_instr = memf(m_pc);
            if (was_wb) m_pc = bt ? tgt : m_pc + 4'd1;
            m_stage = {m_stage[3:0], m_stage[4]};
            pc_req = was_wb ? (bt ? "R5" : "R4") : (bt ? "R6" : "R3");
            ir_req = was_f ? "R7" : "R8";
        end
        @(negedge clk);
        chk("R2", 32'(stage_en), 32'(m_stage));
        chk(pc_req, 32'(mem_addr), 32'(m_pc));
        chk(ir_req, 32'(instr), 32'(m_instr));
    endtask

    // One full instruction: random noise on the ALU inputs before writeback, then the given decision in writeback.
    task automatic run_instr(input logic bt, input logic [AW-1:0] tgt, input bit noise);
        for (int s = 0; s < 4; s++)
            cyc(noise ? 1'($urandom) : 1'b0, noise ? AW'($urandom) : '0, 1'b1);
        cyc(bt, tgt, 1'b1);
    endtask

    initial begin
        int loops;
        logic [AW-1:0] tgt;
        void'($urandom(32'd7321));
        cyc(1'b0, '0, 1'b0);
        cyc(1'b1, 4'h9, 1'b0);
        // R1: reset state visible at the ports
        chk("R1", 32'(mem_addr), 32'd0);
        chk("R1", 32'(stage_en), 32'h01);
        chk("R1", 32'(instr), 32'd0);

        // Directed program: backward branch from 5 to 2, taken twice, run until the counter reaches 8
        loops = 0;
        while (m_pc != 4'd8) begin
            if (m_pc == 4'd5 && loops < 2) begin
                loops++;
                run_instr(1'b1, 4'd2, 1'b0);
                cyc(1'b0, '0, 1'b1);
                // R9: the fetch right after the branch captures the target word
                chk("R9", 32'(instr), 32'(memf(4'd2)));
                for (int s = 0; s < 4; s++) cyc(1'b0, '0, 1'b1);
            end else begin
                run_instr(1'b0, '0, 1'b0);
            end
        end
        chk("R4", 32'(mem_addr), 32'd8);

        // Wrap: branch to the top address, then step
        run_instr(1'b1, 4'hF, 1'b1);
        run_instr(1'b0, '0, 1'b1);
        chk("R10", 32'(mem_addr), 32'd0);

        // Random phase: noise on the ALU inputs in every stage, random branches in writeback
        for (int i = 0; i < 60; i++) begin
            tgt = AW'($urandom);
            run_instr(($urandom % 4) == 0, tgt, 1'b1);
        end

        // Reset in the middle of an instruction, with the branch flag raised
        cyc(1'b0, '0, 1'b1);
        cyc(1'b1, 4'h7, 1'b1);
        cyc(1'b1, 4'h7, 1'b0);
        chk("R11", 32'(mem_addr), 32'd0);
        chk("R11", 32'(stage_en), 32'h01);
        for (int i = 0; i < 3; i++) run_instr(1'b0, '0, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule